// File: doc/BRIEF.md
# Iterative Triangular-Number Engine

The engine takes an unsigned 4-bit count `n_in`, which must be non-zero, and produces the sum 1 + 2 + ... + n on a 7-bit result bus. It does this with a small controller that drives a datapath. The datapath holds a down-counting index register and an accumulator register. It also has a decrement unit, a zero-extending adder, a zero detector on the decremented index, and a select multiplexer in front of each register. The engine never stops. Once a result has been presented, it samples the count input again and begins the next sum.

The controller has three named states, and the encoding matters:

- `ST_INIT` (2'b00) clears the accumulator and loads the index from `n_in`. It always moves to `ST_LOOP`.
- `ST_LOOP` (2'b01) adds the index to the accumulator and decrements the index. It moves to `ST_DONE` when the decremented index is zero. Otherwise it stays in `ST_LOOP`.
- `ST_DONE` (2'b10) raises `x_done` and writes neither register. It always moves to `ST_INIT`.
- The spare code 2'b11 writes nothing and moves to `ST_INIT`.

All control lines are decoded combinationally from the state register alone. A computation for count n therefore takes n + 2 cycles.

Top module: `serial_sum_engine`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in `ST_INIT` and clears the accumulator, the index and `x_done`. While reset is held, `x_out` reads 0 and `x_done` reads 0.
- R2: In `ST_INIT`, the rising edge loads the accumulator with 0 and the index with `n_in`. In the cycle that follows, `x_out` reads 0 and `x_done` reads 0.
- R3: Each `ST_LOOP` edge adds the zero-extended index to the accumulator and decrements the index. In the cycle after the first loop edge, `x_out` equals n.
- R4: `x_done` is 1 for exactly one cycle, the `ST_DONE` cycle, and is 0 in the following `ST_INIT` cycle.
- R5: While `x_done` is 1, `x_out` equals n*(n+1)/2 for every n from 1 to 15. The largest value is 120.
- R6: Counting the `ST_INIT` cycle that samples n as cycle 0, `x_done` is 0 in cycles 1 to n and 1 in cycle n+1. A new count is sampled every n + 2 cycles.
- R7: `n_in` is sampled only at the `ST_INIT` edge. Changing it during `ST_LOOP` or `ST_DONE` does not change the result.
- R8: `x_out` keeps the finished sum through the `ST_DONE` cycle and the `ST_INIT` cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| n_in | input | 4 | Upper bound of the sum, non-zero |
| x_out | output | 7 | Accumulator value; the final sum while `x_done` is high |
| x_done | output | 1 | One-cycle result-valid pulse |

## Verification
In the final `ST_LOOP` cycle, the last addition of 1 and the exit decision taken from the zero detector happen together. Count 1 drives that coincidence into the very first loop cycle, and count 15 drives it to the end of the longest run. Both are judged by the exact sum and by the cycle in which `x_done` rises. A second coincidence occurs when the `x_done` pulse is followed at once by the sampling of the next count. A sweep of every count, run back to back, checks both that the sum is held and that the next count is captured. During the scrambled sweep, `n_in` is changed in every non-initial cycle so that any sampling outside `ST_INIT` shows up in the result.

// File: rtl/sumfsm_pkg.sv
package sumfsm_pkg;

    // Encoding is part of the behaviour: 00 init, 01 loop, 10 done.
    typedef enum logic [1:0] {
        ST_INIT  = 2'b00,
        ST_LOOP  = 2'b01,
        ST_DONE  = 2'b10,
        ST_SPARE = 2'b11
    } sum_state_e;

    typedef struct packed {
        logic acc_we;     // accumulator write enable
        logic acc_clr;    // 1: accumulator source is zero, 0: adder
        logic idx_we;     // index write enable
        logic idx_load;   // 1: index source is n_in, 0: decrementer
        logic done;       // result valid
    } sum_ctrl_t;

endpackage

// File: rtl/sum_ctrl.sv
module sum_ctrl
    import sumfsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       last_iter,
    output sum_state_e state_o,
    output sum_ctrl_t  ctrl_o
);

    sum_state_e state_q;
    sum_state_e state_d;

    // State register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and output decode process: every signal set in every state
    always_comb begin
        state_d = ST_INIT;
        ctrl_o  = '0;
        unique case (state_q)
            ST_INIT: begin
                ctrl_o  = '{acc_we: 1'b1, acc_clr: 1'b1, idx_we: 1'b1, idx_load: 1'b1, done: 1'b0};
                state_d = ST_LOOP;
            end
            ST_LOOP: begin
                ctrl_o  = '{acc_we: 1'b1, acc_clr: 1'b0, idx_we: 1'b1, idx_load: 1'b0, done: 1'b0};
                state_d = last_iter ? ST_DONE : ST_LOOP;
            end
            ST_DONE: begin
                ctrl_o  = '{acc_we: 1'b0, acc_clr: 1'b0, idx_we: 1'b0, idx_load: 1'b0, done: 1'b1};
                state_d = ST_INIT;
            end
            ST_SPARE: begin
                ctrl_o  = '0;
                state_d = ST_INIT;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/sum_zero_det.sv
module sum_zero_det #(
    parameter int W = 4
) (
    input  logic [W-1:0] val,
    output logic         is_zero
);

    assign is_zero = ~|val;

endmodule

// File: rtl/sum_datapath.sv
module sum_datapath
    import sumfsm_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int ACC_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] n_in,
    input  sum_ctrl_t        ctrl,
    output logic [IDX_W-1:0] idx_o,
    output logic [ACC_W-1:0] acc_o,
    output logic             last_o
);

    localparam int PAD_W = ACC_W - IDX_W;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_dec;
    logic [IDX_W-1:0] idx_src;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] acc_src;

    // Decrement unit and zero-extending adder
    assign idx_dec = idx_q - IDX_W'(1);
    assign acc_sum = acc_q + {{PAD_W{1'b0}}, idx_q};

    // Source multiplexers
    assign idx_src = ctrl.idx_load ? n_in : idx_dec;
    assign acc_src = ctrl.acc_clr ? '0 : acc_sum;

    // Exit flag taken from the decremented index
    sum_zero_det #(.W(IDX_W)) u_zero (
        .val     (idx_dec),
        .is_zero (last_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (ctrl.idx_we) begin
            idx_q <= idx_src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (ctrl.acc_we) begin
            acc_q <= acc_src;
        end
    end

    assign idx_o = idx_q;
    assign acc_o = acc_q;

endmodule

// File: rtl/serial_sum_engine.sv
module serial_sum_engine
    import sumfsm_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int ACC_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] n_in,
    output logic [ACC_W-1:0] x_out,
    output logic             x_done
);

    sum_state_e       state_w;
    sum_ctrl_t        ctrl_w;
    logic             last_w;
    logic [IDX_W-1:0] idx_w;
    logic [1:0]       state_bits;

    sum_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .last_iter (last_w),
        .state_o   (state_w),
        .ctrl_o    (ctrl_w)
    );

    sum_datapath #(.IDX_W(IDX_W), .ACC_W(ACC_W)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .n_in   (n_in),
        .ctrl   (ctrl_w),
        .idx_o  (idx_w),
        .acc_o  (x_out),
        .last_o (last_w)
    );

    assign x_done     = ctrl_w.done;
    assign state_bits = state_w;

endmodule

// File: rtl/sum_checker.sv
module sum_checker #(
    parameter int IDX_W = 4,
    parameter int ACC_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] n_in,
    input logic [ACC_W-1:0] x_out,
    input logic             x_done,
    input logic [1:0]       state,
    input logic [IDX_W-1:0] idx
);

    localparam int PAD_W = ACC_W - IDX_W;

    logic [ACC_W-1:0] idx_ext;
    assign idx_ext = {{PAD_W{1'b0}}, idx};

    assert_init_load_R2: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b00) |=> (state == 2'b01 && x_out == '0 && idx == $past(n_in)));

    assert_loop_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b01) |=> (x_out == ACC_W'($past(x_out) + $past(idx_ext))));

    assert_loop_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b01 && idx == IDX_W'(1)) |=> (state == 2'b10));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        x_done |=> (!x_done && state == 2'b00));

    assert_hold_result_R8: assert property (@(posedge clk) disable iff (rst)
        x_done |=> $stable(x_out));

    assert_no_spare_R1: assert property (@(posedge clk) disable iff (rst)
        state != 2'b11);

endmodule

bind serial_sum_engine sum_checker #(.IDX_W(IDX_W), .ACC_W(ACC_W)) u_sum_chk (
    .clk    (clk),
    .rst    (rst),
    .n_in   (n_in),
    .x_out  (x_out),
    .x_done (x_done),
    .state  (state_bits),
    .idx    (idx_w)
);

// File: tb/test_serial_sum_engine.sv
module test_serial_sum_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] n_in = 4'd0;
    logic [6:0] x_out;
    logic       x_done;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    serial_sum_engine i_serial_sum_engine (
        .clk    (clk),
        .rst    (rst),
        .n_in   (n_in),
        .x_out  (x_out),
        .x_done (x_done)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge that lies in an initial-state cycle with rst low.
    task automatic run_one(input int n, input bit scramble);
        int sum = n * (n + 1) / 2;
        n_in = 4'(n);
        for (int k = 1; k <= n + 1; k++) begin
            @(negedge clk);
            if (scramble) n_in = 4'(~n + k);                       // R7 disturbance
            if (k == 1) check(x_out == 7'd0, "R2 cleared accumulator", x_out, 0);
            if (k == 2) check(x_out == 7'(n), "R3 first add", x_out, n);
            if (k <= n) check(x_done == 1'b0, "R6 done low while looping", x_done, 0);
            else begin
                check(x_done == 1'b1, "R6 done at cycle n+1", x_done, 1);
                check(x_out == 7'(sum), scramble ? "R7 result with moving n_in" : "R5 sum",
                      x_out, sum);
            end
        end
        @(negedge clk);
        check(x_done == 1'b0, "R4 single-cycle pulse", x_done, 0);
        check(x_out == 7'(sum), "R8 result held in init", x_out, sum);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(x_out == 7'd0, "R1 reset x", x_out, 0);
        check(x_done == 1'b0, "R1 reset done", x_done, 0);
        rst = 1'b0;
        for (int n = 1; n <= 15; n++) run_one(n, 1'b0);
        for (int n = 15; n >= 1; n--) run_one(n, 1'b1);
        // Reset in the middle of a computation
        n_in = 4'd9;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(x_out == 7'd0, "R1 mid-run reset x", x_out, 0);
        check(x_done == 1'b0, "R1 mid-run reset done", x_done, 0);
        @(negedge clk);
        rst = 1'b0;
        run_one(1, 1'b0);
        run_one(15, 1'b0);
        run_one(1, 1'b1);
        ended = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!ended) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule